// File: doc/BRIEF.md
# Sequenced Limit Monitor with Interrupts

This block walks a fixed list of nine measurement slots in a repeating loop. Each slot stays current for `SLOT_CYCLES` clock cycles. At the start of a slot it pulses `conv_start` and presents the slot number on `conv_slot`. An external conversion stub answers with a byte on `meas_data`, qualified by `meas_valid`. The block stores each arriving result in a byte-addressed value map and compares it against that slot's programmable high and low limits.

A result above its high limit or below its low limit sets a sticky status bit. Reading the status byte clears it. Each status bit has its own source mask. Two active-low outputs summarise the unmasked status, and each output has its own mask:
- `int_n` is also gated by an enable bit in a configuration byte.
- `alert_n` is not gated by that enable.

All values, limits and controls sit behind a simple register bus. Reads on that bus return data one cycle after the request.

Top module: `limit_monitor`

## Requirements
- R1: `conv_start` is high for the first cycle of every slot. Each slot lasts `SLOT_CYCLES` cycles. `conv_slot` steps 0,1,...,8 and then wraps to 0. After reset the loop starts at slot 0.
- R2: A `meas_valid` cycle stores `meas_data` as the result of the current slot. Slot k is stored at address 20h+k for k=0..5 and at 21h+k for k=6..8. The result can then be read over the bus.
- R3: A stored result sets the status bit of its slot when it is strictly greater than the high limit or strictly less than the low limit. A value equal to either limit sets nothing. Slots 0..7 map to bits 0..7 of status byte 41h. Slot 8 maps to bit 0 of status byte 42h.
- R4: Slot k has its high limit at 2Bh+2k and its low limit at 2Ch+2k. Both are readable and writable. After reset every high limit is FFh and every low limit is 00h.
- R5: Status bits are sticky. A bus read of 41h or 42h returns the current status and clears it in the same cycle. A bit set again only on a new violating result.
- R6: Source masks sit at 43h (bit k masks slot k, k=0..7) and at 44h (bit 0 masks slot 8). A mask bit of 1 removes that slot from both outputs. The status bit is still recorded.
- R7: `int_n` is low exactly when configuration bit 1 (byte 40h) is 1, output mask bit 0 (byte 45h) is 0, and at least one unmasked status bit is set. Configuration resets to 00h, so `int_n` is disabled after reset.
- R8: `alert_n` is low exactly when output mask bit 1 (byte 45h) is 0 and at least one unmasked status bit is set. Configuration bit 1 has no effect on it.
- R9: The following read 00h and ignore writes: unassigned addresses (for example 16h–18h and 1Ah–1Fh), the reserved byte 26h, and the gaps 2Ah and 3Dh. Result bytes are read-only from the bus.
- R10: `bus_rdata` carries the addressed byte in the cycle after the cycle in which `bus_rd` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Register bus byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, one cycle after `bus_rd` |
| meas_valid | input | 1 | Result strobe from conversion stub |
| meas_data | input | 8 | Result byte for current slot |
| conv_start | output | 1 | High in first cycle of each slot |
| conv_slot | output | 4 | Current slot number 0..8 |
| int_n | output | 1 | Main interrupt, active low, gated by configuration enable |
| alert_n | output | 1 | Second interrupt, active low |

## Verification
The bench builds the block with `SLOT_CYCLES` = 4, so a full nine-slot loop takes 36 cycles. This makes the slot wrap from 8 back to 0 observable many times in a short run. It also lets the bench reach any chosen slot, including the odd-placed slot 8 with its status in the second byte, within a few dozen cycles.

// File: rtl/limit_monitor.sv
module limit_monitor #(
  parameter int SLOT_CYCLES = 400000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] bus_addr,
  input  logic       bus_wr,
  input  logic [7:0] bus_wdata,
  input  logic       bus_rd,
  output logic [7:0] bus_rdata,
  input  logic       meas_valid,
  input  logic [7:0] meas_data,
  output logic       conv_start,
  output logic [3:0] conv_slot,
  output logic       int_n,
  output logic       alert_n
);
  localparam int NSLOT = 9;
  localparam int NLIM  = 2 * NSLOT;
  localparam int TW    = SLOT_CYCLES > 1 ? $clog2(SLOT_CYCLES) : 1;

  logic [TW-1:0] tick;
  logic [3:0]    slot;
  logic [7:0]    res [NSLOT];
  logic [7:0]    lim [NLIM];
  logic [7:0]    cfg, mask_lo;
  logic          mask_hi;
  logic [1:0]    omask;
  logic [8:0]    stat, clr, set_vec;
  logic [7:0]    rd_mux;

  wire last_tick = (tick == TW'(SLOT_CYCLES - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tick <= '0;
      slot <= '0;
    end else if (last_tick) begin
      tick <= '0;
      slot <= (slot == 4'(NSLOT - 1)) ? 4'd0 : 4'(slot + 1);
    end else begin
      tick <= tick + 1'b1;
    end
  end

  assign conv_start = (tick == '0);
  assign conv_slot  = slot;

  wire [7:0] hi_lim = lim[{slot, 1'b0}];
  wire [7:0] lo_lim = lim[{slot, 1'b1}];
  wire       viol   = meas_valid && (meas_data > hi_lim || meas_data < lo_lim);
  assign set_vec = viol ? (9'd1 << slot) : 9'd0;

  wire       res_hit = bus_addr >= 8'h20 && bus_addr <= 8'h29 && bus_addr != 8'h26;
  wire [3:0] res_idx = (bus_addr < 8'h26) ? bus_addr[3:0] : 4'(bus_addr[3:0] - 4'd1);
  wire       lim_hit = bus_addr >= 8'h2B && bus_addr <= 8'h3C;
  wire [4:0] lim_idx = 5'(bus_addr - 8'h2B);

  assign clr = {bus_rd && bus_addr == 8'h42, {8{bus_rd && bus_addr == 8'h41}}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat    <= '0;
      cfg     <= '0;
      mask_lo <= '0;
      mask_hi <= 1'b0;
      omask   <= '0;
    end else begin
      stat <= (stat & ~clr) | set_vec;
      if (bus_wr && bus_addr == 8'h40) cfg     <= bus_wdata;
      if (bus_wr && bus_addr == 8'h43) mask_lo <= bus_wdata;
      if (bus_wr && bus_addr == 8'h44) mask_hi <= bus_wdata[0];
      if (bus_wr && bus_addr == 8'h45) omask   <= bus_wdata[1:0];
    end
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < NSLOT; k++) begin
      if (!rst_n)                        res[k] <= '0;
      else if (meas_valid && slot == 4'(k)) res[k] <= meas_data;
    end
    for (int j = 0; j < NLIM; j++) begin
      if (!rst_n)                                   lim[j] <= (j % 2 == 0) ? 8'hFF : 8'h00;
      else if (bus_wr && lim_hit && lim_idx == 5'(j)) lim[j] <= bus_wdata;
    end
  end

  always_comb begin
    rd_mux = 8'h00;
    if (res_hit)      rd_mux = res[res_idx];
    else if (lim_hit) rd_mux = lim[lim_idx];
    else begin
      case (bus_addr)
        8'h40:   rd_mux = cfg;
        8'h41:   rd_mux = stat[7:0];
        8'h42:   rd_mux = {7'd0, stat[8]};
        8'h43:   rd_mux = mask_lo;
        8'h44:   rd_mux = {7'd0, mask_hi};
        8'h45:   rd_mux = {6'd0, omask};
        default: rd_mux = 8'h00;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  wire pend = |(stat & ~{mask_hi, mask_lo});
  assign int_n   = ~(cfg[1] & ~omask[0] & pend);
  assign alert_n = ~(~omask[1] & pend);

  assert_slot_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    slot <= 4'(NSLOT - 1));
  assert_slot_moves_at_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (slot != $past(slot)) |-> conv_start);
  assert_violation_recorded_R3: assert property (@(posedge clk) disable iff (!rst_n)
    viol |=> ((stat & $past(set_vec)) != 9'd0));
  assert_sticky_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (stat[0] && !(bus_rd && bus_addr == 8'h41)) |=> stat[0]);
  assert_sticky_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (stat[8] && !(bus_rd && bus_addr == 8'h42)) |=> stat[8]);
  assert_quiet_outputs_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stat == 9'd0) |-> (int_n && alert_n));
  assert_enable_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg[1] |-> int_n);
endmodule

// File: tb/sim_limit_monitor.sv
module sim_limit_monitor;
  localparam int CLK_PERIOD = 10;
  localparam int SLOTS = 4;

  logic clk = 0, rst_n = 0;
  logic [7:0] bus_addr = 0, bus_wdata = 0, meas_data = 0;
  logic bus_wr = 0, bus_rd = 0, meas_valid = 0;
  logic [7:0] bus_rdata;
  logic conv_start, int_n, alert_n;
  logic [3:0] conv_slot;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  limit_monitor #(.SLOT_CYCLES(SLOTS)) u0 (
    .clk, .rst_n, .bus_addr, .bus_wr, .bus_wdata, .bus_rd, .bus_rdata,
    .meas_valid, .meas_data, .conv_start, .conv_slot, .int_n, .alert_n);

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1;
    @(negedge clk);
    bus_rd = 0;
    d = bus_rdata;
  endtask

  task automatic wait_slot(int s);
    for (int i = 0; i < 80; i++) begin
      if (conv_start && conv_slot == 4'(s)) return;
      @(negedge clk);
    end
  endtask

  task automatic meas(int s, logic [7:0] v);
    wait_slot(s);
    meas_data = v; meas_valid = 1;
    @(negedge clk);
    meas_valid = 0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R7 int_n after reset", {7'd0, int_n}, 8'd1);
    chk("R8 alert_n after reset", {7'd0, alert_n}, 8'd1);
    chk("R1 first slot", {4'd0, conv_slot}, 8'd0);
    rd(8'h40, d); chk("R7 config reset", d, 8'h00);
    rd(8'h2B, d); chk("R4 high limit reset", d, 8'hFF);
    rd(8'h3C, d); chk("R4 low limit reset", d, 8'h00);
    rd(8'h41, d); chk("R5 status reset", d, 8'h00);
  endtask

  task automatic t_loop();
    int prev, cnt;
    wait_slot(0);
    prev = 0;
    for (int n = 0; n < 12; n++) begin
      cnt = 0;
      do begin @(negedge clk); cnt++; end while (!conv_start && cnt < 20);
      chk("R1 slot length", 8'(cnt), 8'(SLOTS));
      chk("R1 slot order", {4'd0, conv_slot}, 8'((prev + 1) % 9));
      prev = conv_slot;
    end
  endtask

  task automatic t_store();
    logic [7:0] d;
    meas(2, 8'h5A); rd(8'h22, d); chk("R2 slot 2 result", d, 8'h5A);
    meas(7, 8'hC3); rd(8'h28, d); chk("R2 slot 7 result", d, 8'hC3);
    meas(8, 8'h11); rd(8'h29, d); chk("R2 slot 8 result", d, 8'h11);
    rd(8'h41, d); rd(8'h42, d);
  endtask

  task automatic t_limits();
    logic [7:0] d;
    wr(8'h2D, 8'h80); wr(8'h2E, 8'h20);
    rd(8'h2D, d); chk("R4 R10 high limit readback", d, 8'h80);
    rd(8'h2E, d); chk("R4 low limit readback", d, 8'h20);
    meas(1, 8'h80); rd(8'h41, d); chk("R3 equal high no violation", d, 8'h00);
    meas(1, 8'h81); rd(8'h41, d); chk("R3 above high", d, 8'h02);
    meas(1, 8'h20); rd(8'h41, d); chk("R3 equal low no violation", d, 8'h00);
    meas(1, 8'h1F); rd(8'h41, d); chk("R3 below low", d, 8'h02);
    wr(8'h3B, 8'h10);
    meas(8, 8'h11);
    rd(8'h42, d); chk("R3 slot 8 in second byte", d, 8'h01);
    rd(8'h41, d); chk("R3 slot 8 not in first byte", d, 8'h00);
  endtask

  task automatic t_sticky();
    logic [7:0] d;
    meas(1, 8'hF0);
    repeat (20) @(negedge clk);
    rd(8'h41, d); chk("R5 status held until read", d, 8'h02);
    rd(8'h41, d); chk("R5 cleared by read", d, 8'h00);
  endtask

  task automatic t_outputs();
    logic [7:0] d;
    meas(1, 8'hF0);
    chk("R7 int_n disabled by config", {7'd0, int_n}, 8'd1);
    chk("R8 alert_n ignores config", {7'd0, alert_n}, 8'd0);
    wr(8'h40, 8'h02);
    chk("R7 int_n enabled", {7'd0, int_n}, 8'd0);
    wr(8'h45, 8'h01);
    chk("R7 main output mask", {7'd0, int_n}, 8'd1);
    chk("R8 alert unaffected by main mask", {7'd0, alert_n}, 8'd0);
    wr(8'h45, 8'h02);
    chk("R8 second output mask", {7'd0, alert_n}, 8'd1);
    chk("R7 int unaffected by second mask", {7'd0, int_n}, 8'd0);
    wr(8'h45, 8'h00); wr(8'h43, 8'h02);
    chk("R6 source mask int_n", {7'd0, int_n}, 8'd1);
    chk("R6 source mask alert_n", {7'd0, alert_n}, 8'd1);
    rd(8'h41, d); chk("R6 masked status still recorded", d, 8'h02);
    wr(8'h43, 8'h00); wr(8'h40, 8'h00);
  endtask

  task automatic t_unassigned();
    logic [7:0] d, v;
    wr(8'h17, 8'hAA); rd(8'h17, d); chk("R9 unassigned 17h", d, 8'h00);
    wr(8'h1C, 8'h55); rd(8'h1C, d); chk("R9 unassigned 1Ch", d, 8'h00);
    wr(8'h26, 8'h77); rd(8'h26, d); chk("R9 reserved 26h", d, 8'h00);
    wr(8'h2A, 8'h66); rd(8'h2A, d); chk("R9 gap 2Ah", d, 8'h00);
    wr(8'h3D, 8'h99); rd(8'h3D, d); chk("R9 gap 3Dh", d, 8'h00);
    rd(8'h22, v); wr(8'h22, ~v); rd(8'h22, d); chk("R9 result read-only", d, v);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_loop();
    t_store();
    t_limits();
    t_sticky();
    t_outputs();
    t_unassigned();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule